// File: doc/BRIEF.md
# GPIO Interrupt Event Detector

This block watches the pins of a general-purpose I/O bank and turns selected pin activity into interrupt requests. Each pin has four independent detect-type bits: one for a held-low level, one for a held-high level, one for a rising edge and one for a falling edge. When both edge bits are set, the pin reacts to either edge. Pin inputs first pass through a two-flop synchronizer. A detected event sets that pin's bit in a shared raw status register.

The block has two interrupt lines. Each line has its own enable mask, and software changes a mask only through a write-one-to-set alias or a write-one-to-clear alias. For each line, a masked status view is the raw status ANDed with that line's mask. The line's request output is the OR of its masked view. Software acknowledges an event by writing a one to either masked status register, which clears the raw bit.

All registers sit behind a 32-bit memory-mapped port. Reads are combinational. Writes take effect at the next rising clock edge.

Top module: `gpio_evt_unit`

## Requirements
- R1: A read of offset 0x000 returns the fixed revision word 0x50600801.
- R2: The detect-type registers are read/write, and bit n of each applies to pin n: level-low at 0x140, level-high at 0x144, rising-edge at 0x148 and falling-edge at 0x14C.
- R3: Each pin is synchronized by two flops and then compared with its previous sample. A pin change driven between clock edges sets its raw status bit at the third rising edge after the change, and not before.
- R4: An edge event sets its raw bit, and the bit stays set until software clears it. A pin with both edge bits set reacts to a rise and to a fall.
- R5: A level event sets its raw bit on every cycle its condition holds, so a clear does not remove the bit while the level persists.
- R6: Writing a 1 to a bit of either masked status register (0x02C for line 0, 0x030 for line 1) clears that raw bit, and a 0 bit has no effect. The raw status reads identically at 0x024 and 0x028, and writes to those offsets are ignored.
- R7: For line k, the enable mask is set by ones written to 0x034+4k and cleared by ones written to 0x03C+4k. Zero bits leave the mask unchanged, and a read at either offset returns the mask.
- R8: The masked status of line k equals raw status AND line-k enable, and irq_o[k] is the OR of that masked status.
- R9: When a new event and a software clear hit the same bit in the same cycle, the bit stays set.
- R10: Reset clears every enable mask, every detect-type register, the raw status and the synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | PINS | Asynchronous pin levels |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| irq_o | output | LINES | One interrupt request per line |

## Verification
Read data and the interrupt outputs are combinational. The bench therefore samples them one time unit after driving the address, halfway between clock edges. A register write becomes visible at the first falling edge after the rising edge that captured it. A pin change becomes visible in raw status only after three rising edges, so the bench also reads once after two edges to show the bit is still clear. For a level-low setting on a pin that is already low, raw status follows one edge after the configuration write, and the bench checks both sides of that edge.

// File: rtl/gpio_evt_pkg.sv
`timescale 1ns/1ps
package gpio_evt_pkg;
   localparam int unsigned REV_WORD     = 32'h5060_0801;
   localparam int unsigned OFF_REV      = 'h000;
   localparam int unsigned OFF_RAW_BASE = 'h024;
   localparam int unsigned OFF_MSK_BASE = 'h02C;
   localparam int unsigned OFF_SET_BASE = 'h034;
   localparam int unsigned OFF_CLR_BASE = 'h03C;
   localparam int unsigned OFF_LVL_LO   = 'h140;
   localparam int unsigned OFF_LVL_HI   = 'h144;
   localparam int unsigned OFF_EDG_RISE = 'h148;
   localparam int unsigned OFF_EDG_FALL = 'h14C;
   localparam int unsigned LINE_STRIDE  = 4;
   localparam int unsigned MAX_LINES    = 2;
endpackage

// File: rtl/gpio_evt_sync.sv
`timescale 1ns/1ps
module gpio_evt_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_evt_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[0] <= '0;
            else        stg_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
`timescale 1ns/1ps
module gpio_evt_detect #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] smp_i,
   input  logic [W-1:0] cfg_lo_i,
   input  logic [W-1:0] cfg_hi_i,
   input  logic [W-1:0] cfg_rise_i,
   input  logic [W-1:0] cfg_fall_i,
   output logic [W-1:0] evt_o
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= smp_i;
   end

   for (genvar p = 0; p < W; p++) begin : g_pin
      logic went_up, went_down, lvl_hit;
      assign went_up   = smp_i[p] & ~prev_q[p];
      assign went_down = ~smp_i[p] & prev_q[p];
      assign lvl_hit   = (cfg_hi_i[p] & smp_i[p]) | (cfg_lo_i[p] & ~smp_i[p]);
      assign evt_o[p]  = (cfg_rise_i[p] & went_up) | (cfg_fall_i[p] & went_down) | lvl_hit;
   end
endmodule

// File: rtl/gpio_evt_line.sv
`timescale 1ns/1ps
module gpio_evt_line #(
   parameter int W = 32
) (
   input  logic [W-1:0] raw_i,
   input  logic [W-1:0] en_i,
   output logic [W-1:0] masked_o,
   output logic         irq_o
);
   assign masked_o = raw_i & en_i;
   assign irq_o    = |masked_o;
endmodule

// File: rtl/gpio_evt_regs.sv
`timescale 1ns/1ps
module gpio_evt_regs
   import gpio_evt_pkg::*;
#(
   parameter int PINS   = 32,
   parameter int LINES  = 2,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_sel,
   input  logic                        bus_wr,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [DATA_W-1:0]           bus_wdata,
   output logic [DATA_W-1:0]           bus_rdata,
   input  logic [PINS-1:0]             evt_i,
   input  logic [LINES-1:0][PINS-1:0]  masked_i,
   output logic [PINS-1:0]             raw_o,
   output logic [LINES-1:0][PINS-1:0]  en_o,
   output logic [PINS-1:0]             cfg_lo_o,
   output logic [PINS-1:0]             cfg_hi_o,
   output logic [PINS-1:0]             cfg_rise_o,
   output logic [PINS-1:0]             cfg_fall_o
);
   localparam logic [ADDR_W-1:0] A_REV  = ADDR_W'(OFF_REV);
   localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFF_LVL_LO);
   localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFF_LVL_HI);
   localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(OFF_EDG_RISE);
   localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(OFF_EDG_FALL);

   function automatic logic [ADDR_W-1:0] line_addr(input int unsigned base, input int k);
      return ADDR_W'(base + LINE_STRIDE * k);
   endfunction

   function automatic logic [DATA_W-1:0] widen(input logic [PINS-1:0] v);
      return DATA_W'(v);
   endfunction

   logic                        wr_en, rd_en;
   logic [PINS-1:0]             wbits;
   logic [PINS-1:0]             clr_mask;
   logic [LINES-1:0][PINS-1:0]  set_bits, clr_bits;
   logic [PINS-1:0]             raw_q, lo_q, hi_q, rise_q, fall_q;
   logic [LINES-1:0][PINS-1:0]  en_q;

   assign wr_en = bus_sel & bus_wr;
   assign rd_en = bus_sel & ~bus_wr;
   assign wbits = bus_wdata[PINS-1:0];

   // decode of the per-line write-one aliases
   always_comb begin
      clr_mask = '0;
      set_bits = '0;
      clr_bits = '0;
      for (int k = 0; k < LINES; k++) begin
         if (wr_en && bus_addr == line_addr(OFF_MSK_BASE, k)) clr_mask    = clr_mask | wbits;
         if (wr_en && bus_addr == line_addr(OFF_SET_BASE, k)) set_bits[k] = wbits;
         if (wr_en && bus_addr == line_addr(OFF_CLR_BASE, k)) clr_bits[k] = wbits;
      end
   end

   // raw status: a fresh event outranks an acknowledge on the same bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= (raw_q & ~clr_mask) | evt_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else begin
         for (int k = 0; k < LINES; k++) begin
            en_q[k] <= (en_q[k] | set_bits[k]) & ~clr_bits[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         rise_q <= '0;
         fall_q <= '0;
      end else if (wr_en) begin
         if (bus_addr == A_LO)   lo_q   <= wbits;
         if (bus_addr == A_HI)   hi_q   <= wbits;
         if (bus_addr == A_RISE) rise_q <= wbits;
         if (bus_addr == A_FALL) fall_q <= wbits;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_en) begin
         if (bus_addr == A_REV)  bus_rdata = DATA_W'(REV_WORD);
         if (bus_addr == A_LO)   bus_rdata = widen(lo_q);
         if (bus_addr == A_HI)   bus_rdata = widen(hi_q);
         if (bus_addr == A_RISE) bus_rdata = widen(rise_q);
         if (bus_addr == A_FALL) bus_rdata = widen(fall_q);
         for (int k = 0; k < LINES; k++) begin
            if (bus_addr == line_addr(OFF_RAW_BASE, k)) bus_rdata = widen(raw_q);
            if (bus_addr == line_addr(OFF_MSK_BASE, k)) bus_rdata = widen(masked_i[k]);
            if (bus_addr == line_addr(OFF_SET_BASE, k)) bus_rdata = widen(en_q[k]);
            if (bus_addr == line_addr(OFF_CLR_BASE, k)) bus_rdata = widen(en_q[k]);
         end
      end
   end

   assign raw_o      = raw_q;
   assign en_o       = en_q;
   assign cfg_lo_o   = lo_q;
   assign cfg_hi_o   = hi_q;
   assign cfg_rise_o = rise_q;
   assign cfg_fall_o = fall_q;
endmodule

// File: rtl/gpio_evt_unit.sv
`timescale 1ns/1ps
module gpio_evt_unit
   import gpio_evt_pkg::*;
#(
   parameter int PINS        = 32,
   parameter int LINES       = 2,
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PINS-1:0]   pin_i,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [LINES-1:0]  irq_o
);
   if (PINS < 1 || PINS > DATA_W) begin : g_bad_pins
      $error("gpio_evt_unit: PINS must lie in 1..DATA_W");
   end
   if (LINES < 1 || LINES > MAX_LINES) begin : g_bad_lines
      $error("gpio_evt_unit: LINES must lie in 1..MAX_LINES");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("gpio_evt_unit: ADDR_W too narrow for the register map");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("gpio_evt_unit: DATA_W must be 32");
   end

   logic [PINS-1:0]             pin_sync;
   logic [PINS-1:0]             evt;
   logic [PINS-1:0]             raw_q;
   logic [LINES-1:0][PINS-1:0]  en_q;
   logic [LINES-1:0][PINS-1:0]  masked;
   logic [PINS-1:0]             cfg_lvl_lo, cfg_lvl_hi, cfg_rise, cfg_fall;

   gpio_evt_sync #(.W(PINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (pin_sync)
   );

   gpio_evt_detect #(.W(PINS)) det_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp_i      (pin_sync),
      .cfg_lo_i   (cfg_lvl_lo),
      .cfg_hi_i   (cfg_lvl_hi),
      .cfg_rise_i (cfg_rise),
      .cfg_fall_i (cfg_fall),
      .evt_o      (evt)
   );

   gpio_evt_regs #(
      .PINS(PINS), .LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .evt_i      (evt),
      .masked_i   (masked),
      .raw_o      (raw_q),
      .en_o       (en_q),
      .cfg_lo_o   (cfg_lvl_lo),
      .cfg_hi_o   (cfg_lvl_hi),
      .cfg_rise_o (cfg_rise),
      .cfg_fall_o (cfg_fall)
   );

   for (genvar k = 0; k < LINES; k++) begin : g_line
      gpio_evt_line #(.W(PINS)) line_i (
         .raw_i    (raw_q),
         .en_i     (en_q[k]),
         .masked_o (masked[k]),
         .irq_o    (irq_o[k])
      );
   end
endmodule

// File: rtl/gpio_evt_unit_chk.sv
`timescale 1ns/1ps
module gpio_evt_unit_chk #(
   parameter int PINS   = 32,
   parameter int LINES  = 2,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        bus_sel,
   input logic                        bus_wr,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic [DATA_W-1:0]           bus_wdata,
   input logic [DATA_W-1:0]           bus_rdata,
   input logic [PINS-1:0]             raw,
   input logic [LINES-1:0][PINS-1:0]  en,
   input logic [PINS-1:0]             pin_s,
   input logic [PINS-1:0]             lvl_hi,
   input logic [LINES-1:0]            irq
);
   logic            wr_en;
   logic            en_touch;
   logic [PINS-1:0] ack_bits;

   assign wr_en    = bus_sel & bus_wr;
   assign en_touch = wr_en && bus_addr >= ADDR_W'('h034) && bus_addr <= ADDR_W'('h040);
   assign ack_bits = (wr_en && (bus_addr == ADDR_W'('h02C) || bus_addr == ADDR_W'('h030)))
                     ? bus_wdata[PINS-1:0] : '0;

   p_rev_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == '0) |-> bus_rdata == 32'h5060_0801);

   // R4 and R6: a raw bit only falls when acknowledged
   p_raw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(raw) & ~$past(ack_bits)) & ~raw) == '0));

   p_level_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(lvl_hi) & $past(pin_s)) & ~raw) == '0));

   p_en_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en_touch |=> $stable(en));

   p_reset_clear_r10: assert property (@(posedge clk)
      !rst_n |-> (raw == '0 && en == '0 && irq == '0));

   for (genvar k = 0; k < LINES; k++) begin : g_irq
      p_irq_view_r8: assert property (@(posedge clk) disable iff (!rst_n)
         irq[k] == |(raw & en[k]));
   end
endmodule

bind gpio_evt_unit gpio_evt_unit_chk #(
   .PINS(PINS), .LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .raw       (raw_q),
   .en        (en_q),
   .pin_s     (pin_sync),
   .lvl_hi    (cfg_lvl_hi),
   .irq       (irq_o)
);

// File: tb/gpio_evt_unit_tb_top.sv
`timescale 1ns/1ps
module gpio_evt_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYC   = 20000;

   localparam logic [2:0] K_WR = 3'd0, K_RD = 3'd1, K_PIN = 3'd2, K_WAIT = 3'd3, K_IRQ = 3'd4;
   localparam int NSTEP = 60;

   // fields: kind, offset, data, expected, requirement number
   localparam logic [86:0] STEPS [NSTEP] = '{
      {K_RD,  12'h000, 32'h0, 32'h5060_0801, 8'd1},  // R1
      {K_WR,  12'h148, 32'h1, 32'h0, 8'd2},          // R2 rise on pin 0
      {K_RD,  12'h148, 32'h0, 32'h1, 8'd2},
      {K_WR,  12'h034, 32'h1, 32'h0, 8'd7},          // R7 enable line 0, pin 0
      {K_RD,  12'h034, 32'h0, 32'h1, 8'd7},
      {K_RD,  12'h03C, 32'h0, 32'h1, 8'd7},
      {K_RD,  12'h038, 32'h0, 32'h0, 8'd7},
      {K_PIN, 12'h000, 32'h1, 32'h0, 8'd3},          // R3 pin 0 rises
      {K_WAIT,12'h000, 32'd2, 32'h0, 8'd3},
      {K_RD,  12'h024, 32'h0, 32'h0, 8'd3},          // not yet after two edges
      {K_WAIT,12'h000, 32'd1, 32'h0, 8'd3},
      {K_RD,  12'h024, 32'h0, 32'h1, 8'd3},          // set on third edge
      {K_RD,  12'h028, 32'h0, 32'h1, 8'd6},          // R6 same raw at line-1 alias
      {K_RD,  12'h02C, 32'h0, 32'h1, 8'd8},          // R8
      {K_RD,  12'h030, 32'h0, 32'h0, 8'd8},
      {K_IRQ, 12'h000, 32'h0, 32'h1, 8'd8},
      {K_PIN, 12'h000, 32'h0, 32'h0, 8'd4},          // R4 sticky edge
      {K_WAIT,12'h000, 32'd3, 32'h0, 8'd4},
      {K_RD,  12'h024, 32'h0, 32'h1, 8'd4},
      {K_WR,  12'h02C, 32'h0, 32'h0, 8'd6},          // zero ack does nothing
      {K_RD,  12'h024, 32'h0, 32'h1, 8'd6},
      {K_WR,  12'h02C, 32'h1, 32'h0, 8'd6},
      {K_RD,  12'h024, 32'h0, 32'h0, 8'd6},
      {K_IRQ, 12'h000, 32'h0, 32'h0, 8'd8},
      {K_WR,  12'h024, 32'hFFFF_FFFF, 32'h0, 8'd6},  // raw is read-only
      {K_RD,  12'h024, 32'h0, 32'h0, 8'd6},
      {K_WR,  12'h14C, 32'h2, 32'h0, 8'd2},          // fall on pin 1
      {K_RD,  12'h14C, 32'h0, 32'h2, 8'd2},
      {K_WR,  12'h038, 32'h2, 32'h0, 8'd7},
      {K_PIN, 12'h000, 32'h2, 32'h0, 8'd4},
      {K_WAIT,12'h000, 32'd3, 32'h0, 8'd4},
      {K_RD,  12'h024, 32'h0, 32'h0, 8'd4},          // rise on pin 1 not armed
      {K_PIN, 12'h000, 32'h0, 32'h0, 8'd4},
      {K_WAIT,12'h000, 32'd3, 32'h0, 8'd4},
      {K_RD,  12'h024, 32'h0, 32'h2, 8'd4},
      {K_RD,  12'h030, 32'h0, 32'h2, 8'd8},
      {K_RD,  12'h02C, 32'h0, 32'h0, 8'd8},
      {K_IRQ, 12'h000, 32'h0, 32'h2, 8'd8},
      {K_WR,  12'h030, 32'h2, 32'h0, 8'd6},
      {K_RD,  12'h028, 32'h0, 32'h0, 8'd6},
      {K_WR,  12'h148, 32'h5, 32'h0, 8'd2},          // both edges on pin 2
      {K_WR,  12'h14C, 32'h6, 32'h0, 8'd2},
      {K_PIN, 12'h000, 32'h4, 32'h0, 8'd4},
      {K_WAIT,12'h000, 32'd3, 32'h0, 8'd4},
      {K_RD,  12'h024, 32'h0, 32'h4, 8'd4},
      {K_WR,  12'h02C, 32'h4, 32'h0, 8'd6},
      {K_PIN, 12'h000, 32'h0, 32'h0, 8'd4},
      {K_WAIT,12'h000, 32'd3, 32'h0, 8'd4},
      {K_RD,  12'h024, 32'h0, 32'h4, 8'd4},
      {K_WR,  12'h02C, 32'h4, 32'h0, 8'd6},
      {K_WR,  12'h144, 32'h8, 32'h0, 8'd2},          // R5 level high on pin 3
      {K_PIN, 12'h000, 32'h8, 32'h0, 8'd5},
      {K_WAIT,12'h000, 32'd3, 32'h0, 8'd5},
      {K_RD,  12'h024, 32'h0, 32'h8, 8'd5},
      {K_WR,  12'h02C, 32'h8, 32'h0, 8'd9},          // R9 ack while level holds
      {K_RD,  12'h024, 32'h0, 32'h8, 8'd9},
      {K_PIN, 12'h000, 32'h0, 32'h0, 8'd5},
      {K_WAIT,12'h000, 32'd3, 32'h0, 8'd5},
      {K_WR,  12'h02C, 32'h8, 32'h0, 8'd5},
      {K_RD,  12'h024, 32'h0, 32'h0, 8'd5}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] pin_i;
   logic        bus_sel, bus_wr;
   logic [11:0] bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic [1:0]  irq_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_evt_unit dut_i (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input int req);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      checks++;
      if (bus_rdata !== exp) begin
         errors++;
         $display("FAIL R%0d read %h: got %h expected %h", req, a, bus_rdata, exp);
      end
      bus_sel = 1'b0;
   endtask

   task automatic irq_chk(input logic [1:0] exp, input int req);
      #1;
      checks++;
      if (irq_o !== exp) begin
         errors++;
         $display("FAIL R%0d irq: got %b expected %b", req, irq_o, exp);
      end
   endtask

   task automatic wait_edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0; pin_i = '0;
      bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: state while in reset
      irq_chk(2'b00, 10);
      rd_chk(12'h024, 32'h0, 10);
      rd_chk(12'h034, 32'h0, 10);
      rd_chk(12'h148, 32'h0, 10);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NSTEP; i++) begin
         logic [2:0]  kind;
         logic [11:0] a;
         logic [31:0] d, e;
         logic [7:0]  rq;
         {kind, a, d, e, rq} = STEPS[i];
         case (kind)
            K_WR:    wr(a, d);
            K_RD:    rd_chk(a, e, int'(rq));
            K_PIN:   pin_i = d;
            K_WAIT:  wait_edges(int'(d));
            default: irq_chk(e[1:0], int'(rq));
         endcase
      end

      // R5: level-low on a pin already low, one edge after the write
      wr(12'h140, 32'h10);
      rd_chk(12'h024, 32'h0, 5);
      wait_edges(1);
      rd_chk(12'h024, 32'h10, 5);
      wr(12'h140, 32'h0);
      wr(12'h02C, 32'h10);
      rd_chk(12'h024, 32'h0, 5);

      // R7: clear alias, zero bits, and set alias accumulation
      wr(12'h03C, 32'h1);
      rd_chk(12'h034, 32'h0, 7);
      wr(12'h040, 32'h0);
      rd_chk(12'h038, 32'h2, 7);
      wr(12'h040, 32'h2);
      rd_chk(12'h038, 32'h0, 7);
      wr(12'h034, 32'hF000_0000);
      rd_chk(12'h034, 32'hF000_0000, 7);
      wr(12'h034, 32'h0F00_0000);
      rd_chk(12'h034, 32'hFF00_0000, 7);

      // R8: one level event raising both lines
      wr(12'h144, 32'h20);
      wr(12'h034, 32'h20);
      wr(12'h038, 32'h20);
      pin_i = 32'h20;
      wait_edges(3);
      irq_chk(2'b11, 8);
      rd_chk(12'h030, 32'h20, 8);

      // R10: reset in the middle of activity
      pin_i = '0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk(12'h034, 32'h0, 10);
      rd_chk(12'h038, 32'h0, 10);
      rd_chk(12'h144, 32'h0, 10);
      rd_chk(12'h024, 32'h0, 10);
      irq_chk(2'b00, 10);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not end, got %0d cycles expected fewer", WDOG_CYC);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule